// File: doc/BRIEF.md
# Single-Bus Register Datapath

This block is the data side of a small processor built around one shared internal bus. It holds eight general data registers, a program counter, an instruction register, a memory address register, a memory buffer register, an operand latch for the ALU and a result latch. It makes no decisions of its own. A controller drives one enable line per source, one load line per destination, and one line per ALU function. Every transfer selected in a step commits on the same rising clock edge.

Every path between registers goes over the shared bus, and the ALU sees that bus as its right operand. The left operand comes from the operand latch. The ALU result can only go into the result latch. An addition of two registers therefore takes three steps: load the operand latch, compute into the result latch, then move the result to its destination.

A memory read starts when the address register is loaded and the read line is raised in the same step. The buffer register then captures the returned word one step later. The controller sees the instruction register and a negative flag.

Top module: `sbus_datapath`

## Requirements
- R1: After reset every register, both latches and the negative flag are zero, and the memory read strobe is low.
- R2: The bus carries the value of the single source whose out-enable is high. With no out-enable high it reads zero. Two out-enables must never be high in the same step.
- R3: A register whose in-enable is high loads the bus value on the clock edge that ends the step. A move is done by raising the source out and the destination in together.
- R4: With `alu_add` high, the ALU result is left operand + bus + `carry_in`, modulo 2^DW. The left operand is the operand latch, or zero when `clear_y` is high.
- R5: With `alu_xor` high and `alu_add` low, the ALU result is left operand XOR bus. With neither function line high, the result is the bus value.
- R6: `clear_y` zeroes only the left operand. With `carry_in` and `alu_add` it yields bus + 1. The operand latch keeps its stored value.
- R7: The result latch changes only on an edge where `z_in` is high. An ALU function without `z_in` leaves it unchanged.
- R8: When `mar_in` and `mem_read` are high in a step, `mem_addr` shows the new address in the next step and `mem_rd` is high for exactly that step. The buffer register holds `mem_rdata` of that step from the following step on, and a capture takes precedence over `mbr_in`.
- R9: On each edge with `z_in` high, the negative flag takes bit DW-1 of the ALU result. Otherwise the flag holds.
- R10: `ir_out` drives the low DISPW bits of the instruction register onto the bus, sign-extended to DW bits (bit DISPW-1 copied upward).
- R11: Any number of destinations, including the address register, instruction register and operand latch, may load the same bus value in one step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every transfer commits on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_out | input | NREG | Per-register bus drive enable |
| reg_in | input | NREG | Per-register load enable |
| pc_out | input | 1 | Program counter drives bus |
| pc_in | input | 1 | Program counter loads bus |
| ir_out | input | 1 | Sign-extended displacement drives bus |
| ir_in | input | 1 | Instruction register loads bus |
| mar_in | input | 1 | Address register loads bus |
| mbr_out | input | 1 | Buffer register drives bus |
| mbr_in | input | 1 | Buffer register loads bus |
| y_out | input | 1 | Operand latch drives bus |
| y_in | input | 1 | Operand latch loads bus |
| z_out | input | 1 | Result latch drives bus |
| z_in | input | 1 | Result latch and negative flag load |
| clear_y | input | 1 | Force left ALU operand to zero |
| carry_in | input | 1 | Carry into the adder |
| alu_add | input | 1 | Select addition |
| alu_xor | input | 1 | Select exclusive OR |
| mem_read | input | 1 | Start a memory read |
| mem_addr | output | DW | Memory address (address register) |
| mem_rd | output | 1 | Read strobe, high the step data must be returned |
| mem_rdata | input | DW | Memory read data |
| ir_q | output | DW | Instruction register contents |
| n_flag | output | 1 | Negative flag |
| bus | output | DW | Internal bus value |

## Verification
The embedded assertions check the following on every cycle:
- at most one bus driver is active;
- the result latch holds when it is not loaded;
- the negative flag follows the result sign;
- the address register takes the bus value;
- the strobe follows a read request;
- the buffer register captures the returned word.

The arithmetic results, the sign extension of the displacement and the zero idle bus can only be shown by the bench's step sequences. The same holds for the three-step latency from a fetch to a usable instruction, and for the fact that clearing the operand leaves the stored operand intact.

// File: rtl/sbus_datapath.sv
module sbus_datapath #(
  parameter int DW    = 16,
  parameter int NREG  = 8,
  parameter int DISPW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREG-1:0] reg_out,
  input  logic [NREG-1:0] reg_in,
  input  logic            pc_out,
  input  logic            pc_in,
  input  logic            ir_out,
  input  logic            ir_in,
  input  logic            mar_in,
  input  logic            mbr_out,
  input  logic            mbr_in,
  input  logic            y_out,
  input  logic            y_in,
  input  logic            z_out,
  input  logic            z_in,
  input  logic            clear_y,
  input  logic            carry_in,
  input  logic            alu_add,
  input  logic            alu_xor,
  input  logic            mem_read,
  output logic [DW-1:0]   mem_addr,
  output logic            mem_rd,
  input  logic [DW-1:0]   mem_rdata,
  output logic [DW-1:0]   ir_q,
  output logic            n_flag,
  output logic [DW-1:0]   bus
);
  localparam int NDRV = NREG + 5;

  logic [DW-1:0] rf [NREG];
  logic [DW-1:0] pc_q, mar_q, mbr_q, y_q, z_q;
  logic [DW-1:0] disp, opa, res;
  logic          rd_q, n_q;
  logic [NDRV-1:0] drv;

  assign drv  = {reg_out, pc_out, ir_out, mbr_out, y_out, z_out};
  assign disp = {{(DW-DISPW){ir_q[DISPW-1]}}, ir_q[DISPW-1:0]};

  always_comb begin
    bus = '0;
    for (int i = 0; i < NREG; i++)
      if (reg_out[i]) bus = bus | rf[i];
    if (pc_out)  bus = bus | pc_q;
    if (ir_out)  bus = bus | disp;
    if (mbr_out) bus = bus | mbr_q;
    if (y_out)   bus = bus | y_q;
    if (z_out)   bus = bus | z_q;
  end

  assign opa = clear_y ? '0 : y_q;

  always_comb begin
    if (alu_add)      res = opa + bus + {{(DW-1){1'b0}}, carry_in};
    else if (alu_xor) res = opa ^ bus;
    else              res = bus;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_rf
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)        rf[g] <= '0;
      else if (reg_in[g]) rf[g] <= bus;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0; ir_q <= '0; mar_q <= '0; mbr_q <= '0;
      y_q  <= '0; z_q  <= '0; rd_q  <= 1'b0; n_q  <= 1'b0;
    end else begin
      if (pc_in)  pc_q  <= bus;
      if (ir_in)  ir_q  <= bus;
      if (mar_in) mar_q <= bus;
      if (y_in)   y_q   <= bus;
      if (rd_q)        mbr_q <= mem_rdata;
      else if (mbr_in) mbr_q <= bus;
      if (z_in) begin
        z_q <= res;
        n_q <= res[DW-1];
      end
      rd_q <= mem_read;
    end
  end

  assign mem_addr = mar_q;
  assign mem_rd   = rd_q;
  assign n_flag   = n_q;

  // R2
  single_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(drv));

  // R7
  z_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !z_in |=> $stable(z_q));

  // R9
  n_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    z_in |=> n_flag == z_q[DW-1]);

  // R8
  addr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mar_in |=> mem_addr == $past(bus));

  // R8
  strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_read |=> mem_rd);

  // R8
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> mbr_q == $past(mem_rdata));
endmodule

// File: tb/sbus_datapath_tb.sv
module sbus_datapath_tb;
  localparam int DW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] reg_out, reg_in;
  logic pc_out, pc_in, ir_out, ir_in, mar_in, mbr_out, mbr_in;
  logic y_out, y_in, z_out, z_in, clear_y, carry_in, alu_add, alu_xor, mem_read;
  logic [DW-1:0] mem_addr, mem_rdata, ir_q, bus;
  logic mem_rd, n_flag;

  always #5 clk = ~clk;

  function automatic logic [DW-1:0] memf(input logic [DW-1:0] a);
    return (a * 16'h01F3) ^ 16'hA5C3;
  endfunction

  assign mem_rdata = memf(mem_addr);

  sbus_datapath u_dut (.*);

  typedef struct { int kind; logic [DW-1:0] exp; string req; } item_t;
  item_t sq[$];
  int tests = 0, fails = 0;
  bit done = 0;

  task automatic clr();
    reg_out = '0; reg_in = '0; pc_out = 0; pc_in = 0; ir_out = 0; ir_in = 0;
    mar_in = 0; mbr_out = 0; mbr_in = 0; y_out = 0; y_in = 0; z_out = 0;
    z_in = 0; clear_y = 0; carry_in = 0; alu_add = 0; alu_xor = 0; mem_read = 0;
  endtask

  task automatic go();
    @(posedge clk); #2; clr();
  endtask

  // kinds: 0 bus, 1 n_flag, 2 mem_rd, 3 ir_q, 4 mem_addr
  task automatic expect_v(input int kind, input logic [DW-1:0] exp, input string req);
    item_t it;
    it.kind = kind; it.exp = exp; it.req = req;
    sq.push_back(it);
  endtask

  always @(negedge clk) begin
    while (sq.size() > 0) begin
      item_t it;
      logic [DW-1:0] act;
      it = sq.pop_front();
      case (it.kind)
        0: act = bus;
        1: act = {{(DW-1){1'b0}}, n_flag};
        2: act = {{(DW-1){1'b0}}, mem_rd};
        3: act = ir_q;
        default: act = mem_addr;
      endcase
      tests++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] m1, m2, sum, x;
    clr();
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    m1 = memf(16'h0001);
    m2 = memf(m1);
    sum = m1 + m2;
    x = m1 ^ m2;

    // R1 reset state
    go(); pc_out = 1; expect_v(0, 0, "R1 pc"); expect_v(1, 0, "R1 n");
    expect_v(2, 0, "R1 rd");
    go(); z_out = 1; expect_v(0, 0, "R1 z");
    // R2 idle bus
    go(); expect_v(0, 0, "R2 idle");

    // fetch with increment (R6, R8)
    go(); pc_out = 1; mar_in = 1; mem_read = 1; clear_y = 1; carry_in = 1; alu_add = 1; z_in = 1;
    go(); z_out = 1; pc_in = 1; expect_v(2, 1, "R8 strobe"); expect_v(4, 0, "R8 addr");
    expect_v(1, 0, "R9 n after inc");
    go(); mbr_out = 1; ir_in = 1; expect_v(0, memf(0), "R8 mbr latency");
    expect_v(2, 0, "R8 strobe single");
    go(); ir_out = 1; expect_v(0, 16'hFFC3, "R10 neg disp"); expect_v(3, memf(0), "R10 ir");
    go(); pc_out = 1; expect_v(0, 16'h0001, "R6 pc+1");

    // load r1, r2 and ir together (R11)
    go(); pc_out = 1; mar_in = 1; mem_read = 1;
    go(); expect_v(4, 16'h0001, "R8 addr2");
    go(); mbr_out = 1; reg_in[1] = 1; reg_in[2] = 1; ir_in = 1; expect_v(0, m1, "R8 word1");
    go(); ir_out = 1; expect_v(0, 16'h0030, "R10 pos disp");
    go(); reg_out[2] = 1; expect_v(0, m1, "R11 multi load");

    // read addressed by a data register
    go(); reg_out[1] = 1; mar_in = 1; mem_read = 1;
    go(); expect_v(4, m1, "R8 reg addr");
    go(); mbr_out = 1; reg_in[3] = 1;
    // R3 move
    go(); reg_out[3] = 1; reg_in[5] = 1; expect_v(0, m2, "R3 src");
    go(); reg_out[5] = 1; expect_v(0, m2, "R3 move");
    go(); reg_out[0] = 1; expect_v(0, 0, "R2 r0 untouched");

    // R4 add
    go(); reg_out[1] = 1; y_in = 1;
    go(); reg_out[3] = 1; alu_add = 1; z_in = 1;
    go(); z_out = 1; expect_v(0, sum, "R4 add"); expect_v(1, {15'd0, sum[DW-1]}, "R9 add sign");
    // R7 hold
    go(); reg_out[1] = 1; alu_add = 1; carry_in = 1;
    go(); z_out = 1; expect_v(0, sum, "R7 hold"); expect_v(1, {15'd0, sum[DW-1]}, "R9 hold");
    // R5 xor
    go(); reg_out[3] = 1; alu_xor = 1; z_in = 1;
    go(); z_out = 1; expect_v(0, x, "R5 xor"); expect_v(1, {15'd0, x[DW-1]}, "R9 xor sign");
    // R5 pass-through
    go(); reg_out[1] = 1; z_in = 1;
    go(); z_out = 1; expect_v(0, m1, "R5 pass"); expect_v(1, {15'd0, m1[DW-1]}, "R9 pass sign");
    // R6 clear without carry
    go(); reg_out[3] = 1; clear_y = 1; alu_add = 1; z_in = 1;
    go(); z_out = 1; expect_v(0, m2, "R6 clear");
    go(); y_out = 1; expect_v(0, m1, "R6 y kept");
    go(); go();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule